// File: doc/BRIEF.md
# Keyed Watchdog / Interval Timer

This block is an 8-bit timer for supervising software. It can also serve as a plain interval timer. A free-running prescaler offers eight taps, and a 3-bit select field picks one of them. A single-cycle pulse on the rising edge of the chosen tap advances an 8-bit up-counter. When the counter wraps from 0xFF to 0x00 it sets a sticky overflow flag. In watchdog mode the wrap also raises a one-cycle reset request and records the event in a second flag. Software that is still alive reloads or restarts the counter before that happens.

Software reaches the timer over a simple synchronous bus. There is a 16-bit address, a read strobe with byte read data one cycle later, and a write strobe with 16-bit write data. Every write is a full word whose upper byte carries a key. The counter and the control register share one write address, and the key selects which of the two is written. A wrong key leaves everything untouched, so a stray store from runaway code cannot restart the timer. Each flag can only be cleared by writing a 0 to it.

The timer runs a three-state machine:
- ST_HALT: the enable bit is 0 and the counter is held at zero.
- ST_RUN: the timer counts.
- ST_FIRE: a one-cycle state entered after a watchdog-mode wrap, during which the reset request is high.

The transitions are:
- HALT→RUN when the enable bit is set.
- RUN→HALT when the enable bit is cleared.
- RUN→FIRE on a wrap in watchdog mode.
- FIRE→RUN when still enabled, or FIRE→HALT when not.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the control register reads 0x18, the counter reads 0x00, the reset-status register reads 0x3F, and `ovf_flag` and `rst_req` are low.
- R2: On a read strobe, `bus_rdata` shows the addressed register in the next cycle. The control register is read at 0xFFA8, the counter at 0xFFA9 and the reset-status register at 0xFFAB. Any other address reads 0x00.
- R3: A write of 0xA5 in the upper byte to 0xFFA8 loads the control register. The low byte carries the flag in bit 7, the mode in bit 6 (1 = watchdog), the enable in bit 5 and the tap select in bits 2:0. Bits 4:3 always read 1. A write of 0x5A in the upper byte to the same address loads the low byte into the counter while the timer is enabled. Any other upper byte changes nothing.
- R4: With tap select k, the counter advances once every 2^(k·TAP_STRIDE+1) clock cycles.
- R5: While the enable bit is 0 the counter reads 0x00, does not count, and ignores counter writes.
- R6: A counter wrap from 0xFF to 0x00 sets the overflow flag (control bit 7, also driven on `ovf_flag`). The flag stays set until it is cleared.
- R7: A control write with bit 7 = 0 clears the overflow flag. Bit 7 = 1 leaves the flag unchanged. If a wrap happens in the same cycle as the clear, the flag is set.
- R8: A wrap in watchdog mode drives `rst_req` high for exactly one cycle and sets reset-status bit 7, so that register reads 0xBF. In interval mode (bit 6 = 0) `rst_req` stays low.
- R9: A word write to 0xFFAA with upper byte 0x5A and bit 7 = 0 clears the reset-status flag. Any other key, or bit 7 = 1, leaves it set.
- R10: A write to an address other than 0xFFA8 or 0xFFAA changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Word write strobe |
| bus_wdata | input | 16 | Write data: key in [15:8], value in [7:0] |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| ovf_flag | output | 1 | Sticky overflow flag |
| rst_req | output | 1 | One-cycle reset request on a watchdog wrap |

## Verification
The bench builds the block with TAP_STRIDE = 1, so the eight taps sit on prescaler bits 0 to 7. With tap 0 the counter advances every two cycles, which makes a full wrap, and both flag paths, reachable within a few dozen cycles. Taps 2 and 4 give periods of 8 and 32 cycles, short enough to check the count rate within a few hundred cycles. The slowest tap, 256 cycles per step, holds a loaded counter value steady while it is read back.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;
    localparam int SEL_W  = 3;

    localparam logic [BYTE_W-1:0] KEY_COUNT = 8'h5A;
    localparam logic [BYTE_W-1:0] KEY_CTRL  = 8'hA5;

    localparam logic [ADDR_W-1:0] WA_TIMER = 16'hFFA8;
    localparam logic [ADDR_W-1:0] WA_RESET = 16'hFFAA;
    localparam logic [ADDR_W-1:0] RA_CTRL  = 16'hFFA8;
    localparam logic [ADDR_W-1:0] RA_COUNT = 16'hFFA9;
    localparam logic [ADDR_W-1:0] RA_RESET = 16'hFFAB;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } run_state_t;

    typedef struct packed {
        logic             ovf;
        logic             wd_mode;
        logic             run_en;
        logic [SEL_W-1:0] sel;
    } ctl_t;
endpackage

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
    parameter int SEL_W      = 3,
    parameter int TAP_STRIDE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int TAPS  = 1 << SEL_W;
    localparam int PRE_W = (TAPS - 1) * TAP_STRIDE + 1;

    logic [PRE_W-1:0] pre_q;
    logic [TAPS-1:0]  tap_now;
    logic [TAPS-1:0]  tap_q;
    logic [TAPS-1:0]  rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            tap_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
            tap_q <= tap_now;
        end
    end

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign tap_now[i] = pre_q[i*TAP_STRIDE];
    end

    assign rise = tap_now & ~tap_q;
    assign tick = rise[sel];

    // R4: a tap never yields pulses on consecutive cycles unless the select moved
    p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || (sel != $past(sel))));
endmodule

// File: rtl/kwdt_bus_port.sv
module kwdt_bus_port
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [15:0]       wdata,
    input  logic [BYTE_W-1:0] ctl_view,
    input  logic [BYTE_W-1:0] cnt_view,
    input  logic [BYTE_W-1:0] rst_view,
    output logic              ld_cnt,
    output logic              ld_ctl,
    output logic              clr_rflag,
    output logic [BYTE_W-1:0] wr_byte,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] key;

    assign key       = wdata[15:8];
    assign wr_byte   = wdata[7:0];
    assign ld_cnt    = wr && (addr == WA_TIMER) && (key == KEY_COUNT);
    assign ld_ctl    = wr && (addr == WA_TIMER) && (key == KEY_CTRL);
    assign clr_rflag = wr && (addr == WA_RESET) && (key == KEY_COUNT) && !wdata[7];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            unique case (addr)
                RA_CTRL:  rdata <= ctl_view;
                RA_COUNT: rdata <= cnt_view;
                RA_RESET: rdata <= rst_view;
                default:  rdata <= '0;
            endcase
        end
    end

    // R3: at most one keyed action per bus cycle
    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_cnt, ld_ctl, clr_rflag}));
    // R10: no strobe fires without a write
    p_no_strobe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |-> !(ld_cnt || ld_ctl || clr_rflag));
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ld_cnt,
    input  logic              ld_ctl,
    input  logic              clr_rflag,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [SEL_W-1:0]  sel,
    output logic [BYTE_W-1:0] ctl_view,
    output logic [BYTE_W-1:0] cnt_view,
    output logic [BYTE_W-1:0] rst_view,
    output logic              ovf_flag,
    output logic              rst_req
);
    localparam logic [BYTE_W-1:0] CNT_TOP = {BYTE_W{1'b1}};

    run_state_t        state_q, state_d;
    ctl_t              ctl_q;
    logic [BYTE_W-1:0] cnt_q;
    logic              rflag_q;
    logic              counting;
    logic              wrap;
    logic              wd_wrap;
    logic              unused_bits;

    assign unused_bits = ^wr_byte[4:3];
    assign counting    = (state_q != ST_HALT) && ctl_q.run_en;
    assign wrap        = counting && tick && !ld_cnt && (cnt_q == CNT_TOP);
    assign wd_wrap     = wrap && ctl_q.wd_mode;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (ctl_q.run_en) state_d = ST_RUN;
            ST_RUN: begin
                if (!ctl_q.run_en)  state_d = ST_HALT;
                else if (wd_wrap)   state_d = ST_FIRE;
            end
            ST_FIRE: state_d = ctl_q.run_en ? ST_RUN : ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        rst_req  = (state_q == ST_FIRE);
        ovf_flag = ctl_q.ovf;
        sel      = ctl_q.sel;
        ctl_view = {ctl_q.ovf, ctl_q.wd_mode, ctl_q.run_en, 2'b11, ctl_q.sel};
        cnt_view = cnt_q;
        rst_view = {rflag_q, 7'h3F};
    end

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{ovf: 1'b0, wd_mode: 1'b0, run_en: 1'b0, sel: '0};
        end else begin
            if (ld_ctl) begin
                ctl_q.wd_mode <= wr_byte[6];
                ctl_q.run_en  <= wr_byte[5];
                ctl_q.sel     <= wr_byte[SEL_W-1:0];
            end
            if (wrap)                        ctl_q.ovf <= 1'b1;
            else if (ld_ctl && !wr_byte[7])  ctl_q.ovf <= 1'b0;
        end
    end

    // counter
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!ctl_q.run_en) cnt_q <= '0;
        else if (ld_cnt)       cnt_q <= wr_byte;
        else if (counting && tick) cnt_q <= cnt_q + BYTE_W'(1);
    end

    // reset-status flag
    always_ff @(posedge clk) begin
        if (!rst_n)         rflag_q <= 1'b0;
        else if (wd_wrap)   rflag_q <= 1'b1;
        else if (clr_rflag) rflag_q <= 1'b0;
    end

    // R5: disabled timer holds a zero count
    p_halt_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.run_en |=> (cnt_q == '0));
    // R6: a wrap leaves the overflow flag set
    p_wrap_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && tick && !ld_cnt && cnt_q == CNT_TOP) |=> ctl_q.ovf);
    // R7: the flag only drops through a zero write
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ovf && !(ld_ctl && !wr_byte[7])) |=> ctl_q.ovf);
    // R8: reset request lasts one cycle
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R8: the request is always recorded
    p_pulse_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> rflag_q);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwdt_pkg::*;
#(
    parameter int TAP_STRIDE = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    input  logic        bus_rd,
    output logic [7:0]  bus_rdata,
    output logic        ovf_flag,
    output logic        rst_req
);
    logic              tick;
    logic              ld_cnt, ld_ctl, clr_rflag;
    logic [BYTE_W-1:0] wr_byte;
    logic [SEL_W-1:0]  sel;
    logic [BYTE_W-1:0] ctl_view, cnt_view, rst_view;

    kwdt_prescaler #(
        .SEL_W      (SEL_W),
        .TAP_STRIDE (TAP_STRIDE)
    ) u_prescaler (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .tick  (tick)
    );

    kwdt_bus_port u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .wdata     (bus_wdata),
        .ctl_view  (ctl_view),
        .cnt_view  (cnt_view),
        .rst_view  (rst_view),
        .ld_cnt    (ld_cnt),
        .ld_ctl    (ld_ctl),
        .clr_rflag (clr_rflag),
        .wr_byte   (wr_byte),
        .rdata     (bus_rdata)
    );

    kwdt_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ld_cnt    (ld_cnt),
        .ld_ctl    (ld_ctl),
        .clr_rflag (clr_rflag),
        .wr_byte   (wr_byte),
        .sel       (sel),
        .ctl_view  (ctl_view),
        .cnt_view  (cnt_view),
        .rst_view  (rst_view),
        .ovf_flag  (ovf_flag),
        .rst_req   (rst_req)
    );
endmodule

// File: tb/keyed_watchdog_bench.sv
`timescale 1ns/1ps
module keyed_watchdog_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        ovf_flag;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic rst_prev = 1'b0;
    logic rd_seen = 1'b0;
    bit   done = 1'b0;

    typedef struct {
        int    lo;
        int    hi;
        string tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    always #2 clk = ~clk;

    keyed_watchdog #(.TAP_STRIDE(1)) u_keyed_watchdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .ovf_flag  (ovf_flag),
        .rst_req   (rst_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // driver
    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input int lo, input int hi, input string tag);
        exp_item_t it;
        it.lo = lo;
        it.hi = hi;
        it.tag = tag;
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        sb_q.push_back(it);
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_seen && sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                chk((int'(bus_rdata) >= it.lo) && (int'(bus_rdata) <= it.hi),
                    it.tag, int'(bus_rdata), it.lo);
            end
            if (rst_req && rst_prev)
                chk(1'b0, "R8 rst_req longer than one cycle", 1, 0);
            if (rst_req && !rst_prev) pulses++;
            rst_prev = rst_req;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(ovf_flag == 1'b0, "R1 ovf_flag", ovf_flag, 0);
        chk(rst_req == 1'b0, "R1 rst_req", rst_req, 0);
        rd(16'hFFA8, 8'h18, 8'h18, "R1 control reset");
        rd(16'hFFA9, 8'h00, 8'h00, "R1 counter reset");
        rd(16'hFFAB, 8'h3F, 8'h3F, "R1 reset-status reset");
        // R2 unmapped reads
        rd(16'hFFA7, 0, 0, "R2 unmapped read");
        rd(16'hFFAA, 0, 0, "R2 write-only address read");
        // R3 wrong keys, R10 wrong address
        wr(16'hFFA8, 16'h0027);
        rd(16'hFFA8, 8'h18, 8'h18, "R3 key 0x00 ignored");
        wr(16'hFFA8, 16'h5B27);
        rd(16'hFFA8, 8'h18, 8'h18, "R3 key 0x5B ignored");
        wr(16'hFFA9, 16'hA527);
        rd(16'hFFA8, 8'h18, 8'h18, "R10 write to 0xFFA9 ignored");
        // R4 rate with tap 2 (8 cycles/step)
        wr(16'hFFA8, 16'hA522);
        rd(16'hFFA8, 8'h3A, 8'h3A, "R3 control load");
        idle(80);
        rd(16'hFFA9, 9, 11, "R4 tap 2 rate");
        // R5 disable clears, R4 tap 4 (32 cycles/step)
        wr(16'hFFA8, 16'hA500);
        rd(16'hFFA9, 0, 0, "R5 disable clears counter");
        wr(16'hFFA8, 16'hA524);
        idle(320);
        rd(16'hFFA9, 9, 11, "R4 tap 4 rate");
        // R3 counter load with slow tap
        wr(16'hFFA8, 16'hA527);
        wr(16'hFFA8, 16'h5A80);
        rd(16'hFFA9, 8'h80, 8'h81, "R3 counter load");
        // R5 writes ignored when disabled
        wr(16'hFFA8, 16'hA507);
        rd(16'hFFA9, 0, 0, "R5 counter zero when disabled");
        wr(16'hFFA8, 16'h5A44);
        rd(16'hFFA9, 0, 0, "R5 counter write ignored when disabled");
        idle(50);
        rd(16'hFFA9, 0, 0, "R5 no counting when disabled");
        rd(16'hFFA8, 8'h1F, 8'h1F, "R5 control readback");
        // R6 interval-mode wrap
        wr(16'hFFA8, 16'hA527);
        wr(16'hFFA8, 16'h5AFC);
        wr(16'hFFA8, 16'hA520);
        idle(12);
        chk(ovf_flag == 1'b1, "R6 ovf_flag after wrap", ovf_flag, 1);
        rd(16'hFFA8, 8'hB8, 8'hB8, "R6 control with flag");
        chk(pulses == 0, "R8 no request in interval mode", pulses, 0);
        rd(16'hFFAB, 8'h3F, 8'h3F, "R8 no reset flag in interval mode");
        // R7 write-1 no effect, write-0 clears
        wr(16'hFFA8, 16'hA5A0);
        rd(16'hFFA8, 8'hB8, 8'hB8, "R7 writing 1 keeps flag");
        chk(ovf_flag == 1'b1, "R7 ovf_flag kept", ovf_flag, 1);
        wr(16'hFFA8, 16'hA527);
        rd(16'hFFA8, 8'h3F, 8'h3F, "R7 writing 0 clears flag");
        chk(ovf_flag == 1'b0, "R7 ovf_flag cleared", ovf_flag, 0);
        // R8 watchdog wrap
        wr(16'hFFA8, 16'hA567);
        wr(16'hFFA8, 16'h5AFE);
        wr(16'hFFA8, 16'hA560);
        idle(10);
        chk(pulses == 1, "R8 single reset request", pulses, 1);
        rd(16'hFFAB, 8'hBF, 8'hBF, "R8 reset flag set");
        rd(16'hFFA8, 8'hF8, 8'hF8, "R6 flag also set in watchdog mode");
        wr(16'hFFA8, 16'hA500);
        rd(16'hFFA8, 8'h18, 8'h18, "R7 clear and disable");
        // R9 reset-status clearing
        wr(16'hFFAA, 16'hA500);
        rd(16'hFFAB, 8'hBF, 8'hBF, "R9 wrong key keeps flag");
        wr(16'hFFAA, 16'h5A80);
        rd(16'hFFAB, 8'hBF, 8'hBF, "R9 bit7=1 keeps flag");
        wr(16'hFFAA, 16'h5A00);
        rd(16'hFFAB, 8'h3F, 8'h3F, "R9 keyed zero clears flag");
        idle(4);
        chk(sb_q.size() == 0, "R2 all reads answered", sb_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule